// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block tracks pending interrupt sources, with one source vector per priority level and one level-status bit per level. Each cycle it combines the external level-status vector with a software request vector and arrives at a single priority. When that priority beats the processor's current level, the block raises a take indication and stores the winning priority and the summary of contributing levels. A later acknowledge strobe copies the stored pair into the interrupt-identifier and summary registers that the trap handler reads.

Sources are posted and cleared by a level and source index. A clear-all strobe empties every level at once. A pending flag shows that any level holds work and that the program counter sits on an aligned boundary. Bad indices, acknowledges with nothing stored, and asynchronous-trap requests are not acted on. Each of them raises its own one-cycle error flag.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post with level L and source S in range sets source bit S of level L and marks level L as holding work. The effect is visible on int_pending and take_int two clock edges after the post is sampled.
- R2: A clear drops one source bit. Level L stops holding work only once none of its sources remain set.
- R3: clr_all empties every level in one edge, and it wins over a post sampled in the same cycle.
- R4: int_pending is a register. It is 1 only when some level holds work and pc_lo equals 2'b00 at the same edge.
- R5: Software request bit i counts only for SW_LO <= i <= SW_HI. It gives priority i - SW_LO + 1, the highest such bit wins, and every counted bit appears in the summary at position i. Bits outside the range are ignored.
- R6: External levels EXT_LO to EXT_HI that hold work give priority equal to their level number and set their own summary bit. Any such level overrides a software priority, and the summary is the union of both sets.
- R7: take_int is 1 one edge after an input state in which the resolved priority is nonzero and strictly greater than cur_ipl. The winner and its summary are stored at that edge.
- R8: ack with a stored result copies the stored priority to int_id and the stored summary to int_summary at that edge. ack with nothing stored pulses err_ack and leaves both registers unchanged.
- R9: A post or clear whose level is not below NUM_LVL, or whose source is not below SRC_N, has no effect and pulses err_range one edge later.
- R10: A nonzero ast_req suppresses resolution, so take_int is 0 at the next edge, and it pulses err_async at that edge.
- R11: A post and a clear of the same level and source in the same cycle leave that bit cleared.
- R12: Reset (synchronous, active high) zeroes all pending bits, level status, the stored result, int_id, int_summary, and every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post strobe |
| post_lvl | input | IDX_W | Level index of the post |
| post_src | input | IDX_W | Source index of the post |
| clr_vld | input | 1 | Clear strobe |
| clr_lvl | input | IDX_W | Level index of the clear |
| clr_src | input | IDX_W | Source index of the clear |
| clr_all | input | 1 | Empty every level |
| sw_req | input | NUM_LVL | Software request vector, bit i is level i |
| cur_ipl | input | PRI_W | Current processor priority level |
| pc_lo | input | 2 | Two low bits of the program counter |
| ast_req | input | AST_W | Asynchronous-trap request, any nonzero value is unsupported |
| ack | input | 1 | Commit the stored result |
| int_pending | output | 1 | Some level holds work and the PC is aligned |
| take_int | output | 1 | Interrupt should be taken |
| int_id | output | PRI_W | Committed interrupt identifier (priority) |
| int_summary | output | NUM_LVL | Committed summary of contributing levels |
| err_range | output | 1 | Out-of-range post or clear seen |
| err_ack | output | 1 | Acknowledge with no stored result |
| err_async | output | 1 | Asynchronous-trap request seen |

## Verification
Posts and clears change the pending state at the edge that samples them. int_pending and take_int follow one edge later, two edges after the strobe. Changes on sw_req, cur_ipl, pc_lo and ast_req reach take_int, int_pending and err_async after a single edge. int_id and int_summary change at the edge that samples ack. The bench drives inputs on the falling edge and samples outputs at the falling edge that follows the edge where each result is due. Stimulus stays steady across the whole wait, so no check can see a value from a neighbouring step.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

  // Default geometry shared by the modules and the bench.
  localparam int DEF_NUM_LVL = 32;
  localparam int DEF_SRC_N   = 64;
  localparam int DEF_SW_LO   = 1;
  localparam int DEF_SW_HI   = 15;
  localparam int DEF_EXT_LO  = 16;
  localparam int DEF_EXT_HI  = 31;

  // True when v lies in [lo, hi].
  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int SRC_N   = DEF_SRC_N,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [IDX_W-1:0]   post_lvl,
  input  logic [IDX_W-1:0]   post_src,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_lvl,
  input  logic [IDX_W-1:0]   clr_src,
  input  logic               clr_all,
  output logic [NUM_LVL-1:0] status,
  output logic               err_range
);

  localparam int SRC_W = $clog2(SRC_N);
  localparam logic [SRC_N-1:0] ONE = SRC_N'(1);

  logic post_ok, clr_ok;
  logic [SRC_N-1:0] post_hot, clr_hot;
  logic [SRC_N-1:0] pend_q  [NUM_LVL];
  logic [SRC_N-1:0] pend_nx [NUM_LVL];
  logic [NUM_LVL-1:0] status_q;
  logic [NUM_LVL-1:0] row_any;
  logic err_q;

  // Range qualification of both strobes.
  always_comb begin
    post_ok = post_vld && (int'(post_lvl) < NUM_LVL) && (int'(post_src) < SRC_N);
    clr_ok  = clr_vld  && (int'(clr_lvl)  < NUM_LVL) && (int'(clr_src)  < SRC_N);
    post_hot = post_ok ? (ONE << post_src[SRC_W-1:0]) : '0;
    clr_hot  = clr_ok  ? (ONE << clr_src[SRC_W-1:0])  : '0;
  end

  // One pending row per level; clear beats post, clear-all beats both.
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_row
    logic sel_post, sel_clr;
    assign sel_post = (post_lvl == IDX_W'(l));
    assign sel_clr  = (clr_lvl  == IDX_W'(l));

    always_comb begin
      if (clr_all) pend_nx[l] = '0;
      else pend_nx[l] = (pend_q[l] | (sel_post ? post_hot : '0))
                        & ~(sel_clr ? clr_hot : '0);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[l]   <= '0;
        status_q[l] <= 1'b0;
      end else begin
        pend_q[l]   <= pend_nx[l];
        status_q[l] <= |pend_nx[l];
      end
    end

    assign row_any[l] = |pend_q[l];
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (post_vld && !post_ok) || (clr_vld && !clr_ok);
  end

  assign status    = status_q;
  assign err_range = err_q;

  // R2: a level's status bit tracks whether any of its sources remain.
  p_status_rows_r2: assert property (@(posedge clk) disable iff (rst)
    status_q == row_any);

  // R3: clear-all leaves no level holding work.
  p_clear_all_r3: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (status_q == '0));

  // R9: a rejected post with no other request changes nothing.
  p_bad_post_r9: assert property (@(posedge clk) disable iff (rst)
    (post_vld && !post_ok && !clr_vld && !clr_all) |=> $stable(status_q));

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int SW_LO   = DEF_SW_LO,
  parameter int SW_HI   = DEF_SW_HI,
  parameter int EXT_LO  = DEF_EXT_LO,
  parameter int EXT_HI  = DEF_EXT_HI,
  localparam int PRI_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [NUM_LVL-1:0] status,
  output logic [PRI_W-1:0]   pri,
  output logic [NUM_LVL-1:0] summary
);

  logic [NUM_LVL-1:0] sw_mask, ext_mask;

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_mask
    assign sw_mask[i]  = in_span(i, SW_LO, SW_HI);
    assign ext_mask[i] = in_span(i, EXT_LO, EXT_HI);
  end

  // Software range first, external range second: the later scan
  // overwrites, so any external level outranks software requests.
  always_comb begin
    pri = '0;
    for (int i = SW_LO; i <= SW_HI; i++)
      if (sw_req[i]) pri = PRI_W'(i - SW_LO + 1);
    for (int i = EXT_LO; i <= EXT_HI; i++)
      if (status[i]) pri = PRI_W'(i);
    summary = (sw_req & sw_mask) | (status & ext_mask);
  end

endmodule

// File: rtl/irq_commit.sv
module irq_commit
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int AST_W   = 4,
  localparam int PRI_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRI_W-1:0]   res_pri,
  input  logic [NUM_LVL-1:0] res_sum,
  input  logic [PRI_W-1:0]   cur_ipl,
  input  logic [AST_W-1:0]   ast_req,
  input  logic               ack,
  input  logic               any_work,
  input  logic [1:0]         pc_lo,
  output logic               int_pending,
  output logic               take_int,
  output logic [PRI_W-1:0]   int_id,
  output logic [NUM_LVL-1:0] int_summary,
  output logic               err_ack,
  output logic               err_async
);

  logic take_c, async_c;
  logic take_q, valid_q, pend_q, eack_q, easync_q;
  logic [PRI_W-1:0]   lat_pri, id_q;
  logic [NUM_LVL-1:0] lat_sum, sum_q;

  assign async_c = |ast_req;
  assign take_c  = !async_c && (res_pri != '0) && (res_pri > cur_ipl);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q   <= 1'b0;
      valid_q  <= 1'b0;
      pend_q   <= 1'b0;
      eack_q   <= 1'b0;
      easync_q <= 1'b0;
      lat_pri  <= '0;
      lat_sum  <= '0;
      id_q     <= '0;
      sum_q    <= '0;
    end else begin
      take_q   <= take_c;
      pend_q   <= any_work && (pc_lo == 2'b00);
      eack_q   <= ack && !valid_q;
      easync_q <= async_c;
      if (take_c) begin
        lat_pri <= res_pri;
        lat_sum <= res_sum;
      end
      if (ack && valid_q) begin
        id_q  <= lat_pri;
        sum_q <= lat_sum;
      end
      valid_q <= take_c || (valid_q && !ack);
    end
  end

  assign int_pending = pend_q;
  assign take_int    = take_q;
  assign int_id      = id_q;
  assign int_summary = sum_q;
  assign err_ack     = eack_q;
  assign err_async   = easync_q;

  // R4: a misaligned PC masks the pending flag at the next edge.
  p_pc_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_lo != 2'b00) |=> !int_pending);

  // R7: a take is only raised above the sampled priority level.
  p_take_above_r7: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (lat_pri > $past(cur_ipl)));

  // R8: acknowledge with a stored result commits the stored priority.
  p_ack_commit_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && valid_q) |=> (int_id == $past(lat_pri)));

  // R8: acknowledge without a stored result leaves the identifier alone.
  p_ack_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && !valid_q) |=> ($stable(int_id) && $stable(int_summary)));

  // R10: an asynchronous-trap request never resolves into a take.
  p_async_block_r10: assert property (@(posedge clk) disable iff (rst)
    (ast_req != '0) |=> (!take_int && err_async));

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int SRC_N   = DEF_SRC_N,
  parameter int SW_LO   = DEF_SW_LO,
  parameter int SW_HI   = DEF_SW_HI,
  parameter int EXT_LO  = DEF_EXT_LO,
  parameter int EXT_HI  = DEF_EXT_HI,
  parameter int IDX_W   = 8,
  parameter int AST_W   = 4,
  localparam int PRI_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [IDX_W-1:0]   post_lvl,
  input  logic [IDX_W-1:0]   post_src,
  input  logic               clr_vld,
  input  logic [IDX_W-1:0]   clr_lvl,
  input  logic [IDX_W-1:0]   clr_src,
  input  logic               clr_all,
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [PRI_W-1:0]   cur_ipl,
  input  logic [1:0]         pc_lo,
  input  logic [AST_W-1:0]   ast_req,
  input  logic               ack,
  output logic               int_pending,
  output logic               take_int,
  output logic [PRI_W-1:0]   int_id,
  output logic [NUM_LVL-1:0] int_summary,
  output logic               err_range,
  output logic               err_ack,
  output logic               err_async
);

  logic [NUM_LVL-1:0] status;
  logic [PRI_W-1:0]   res_pri;
  logic [NUM_LVL-1:0] res_sum;

  irq_pend_store #(
    .NUM_LVL(NUM_LVL), .SRC_N(SRC_N), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_lvl(post_lvl), .post_src(post_src),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_src(clr_src),
    .clr_all(clr_all),
    .status(status), .err_range(err_range)
  );

  irq_resolver #(
    .NUM_LVL(NUM_LVL), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) u_res (
    .sw_req(sw_req), .status(status),
    .pri(res_pri), .summary(res_sum)
  );

  irq_commit #(
    .NUM_LVL(NUM_LVL), .AST_W(AST_W)
  ) u_commit (
    .clk(clk), .rst(rst),
    .res_pri(res_pri), .res_sum(res_sum),
    .cur_ipl(cur_ipl), .ast_req(ast_req), .ack(ack),
    .any_work(|status), .pc_lo(pc_lo),
    .int_pending(int_pending), .take_int(take_int),
    .int_id(int_id), .int_summary(int_summary),
    .err_ack(err_ack), .err_async(err_async)
  );

endmodule

// File: tb/tb_irq_level_ctrl.sv
`timescale 1ns/1ps
module tb_irq_level_ctrl;

  localparam int NL = 32;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst;
  logic post_vld, clr_vld, clr_all, ack;
  logic [7:0] post_lvl, post_src, clr_lvl, clr_src;
  logic [NL-1:0] sw_req;
  logic [PW-1:0] cur_ipl;
  logic [1:0] pc_lo;
  logic [3:0] ast_req;
  logic int_pending, take_int, err_range, err_ack, err_async;
  logic [PW-1:0] int_id;
  logic [NL-1:0] int_summary;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_level_ctrl dut (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_lvl(post_lvl), .post_src(post_src),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_src(clr_src),
    .clr_all(clr_all), .sw_req(sw_req), .cur_ipl(cur_ipl),
    .pc_lo(pc_lo), .ast_req(ast_req), .ack(ack),
    .int_pending(int_pending), .take_int(take_int),
    .int_id(int_id), .int_summary(int_summary),
    .err_range(err_range), .err_ack(err_ack), .err_async(err_async)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 none, 1 post, 2 clear, 3 clear-all
    logic [7:0]  lvl;
    logic [7:0]  src;
    logic [31:0] sw;
    logic [4:0]  ipl;
    logic        pend;
    logic        take;
    logic [4:0]  id;
    logic [31:0] sum;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{2'd1, 8'd20, 8'd3,  32'h0000_0000, 5'd0,  1'b1, 1'b1, 5'd20, 32'h0010_0000}, // R1 R6
    '{2'd0, 8'd0,  8'd0,  32'h0000_0020, 5'd0,  1'b1, 1'b1, 5'd20, 32'h0010_0020}, // R6 override
    '{2'd2, 8'd20, 8'd3,  32'h0000_0020, 5'd0,  1'b0, 1'b1, 5'd5,  32'h0000_0020}, // R2 R5
    '{2'd0, 8'd0,  8'd0,  32'h0000_8022, 5'd3,  1'b0, 1'b1, 5'd15, 32'h0000_8022}, // R5 highest
    '{2'd0, 8'd0,  8'd0,  32'h0000_8022, 5'd15, 1'b0, 1'b0, 5'd0,  32'h0},         // R7 equal
    '{2'd0, 8'd0,  8'd0,  32'h0001_0001, 5'd0,  1'b0, 1'b0, 5'd0,  32'h0},         // R5 outside
    '{2'd0, 8'd0,  8'd0,  32'h0001_0004, 5'd0,  1'b0, 1'b1, 5'd2,  32'h0000_0004}, // R5 masked sum
    '{2'd1, 8'd31, 8'd63, 32'h0000_0000, 5'd30, 1'b1, 1'b1, 5'd31, 32'h8000_0000}, // R1 edges
    '{2'd0, 8'd0,  8'd0,  32'h0000_0000, 5'd31, 1'b1, 1'b0, 5'd0,  32'h0},         // R7 blocked
    '{2'd1, 8'd17, 8'd0,  32'h0000_0000, 5'd16, 1'b1, 1'b1, 5'd31, 32'h8002_0000}, // R6 union
    '{2'd2, 8'd31, 8'd63, 32'h0000_0000, 5'd16, 1'b1, 1'b1, 5'd17, 32'h0002_0000}, // R2 R7
    '{2'd1, 8'd5,  8'd9,  32'h0000_0000, 5'd0,  1'b1, 1'b1, 5'd17, 32'h0002_0000}, // R6 non-ext level
    '{2'd3, 8'd0,  8'd0,  32'h0000_0000, 5'd0,  1'b0, 1'b0, 5'd0,  32'h0}          // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Drive one strobe cycle, return at the falling edge after it is sampled.
  task automatic strobe(input logic p, input logic c, input logic a,
                        input logic [7:0] lv, input logic [7:0] sr);
    post_vld = p; clr_vld = c; clr_all = a;
    post_lvl = lv; post_src = sr; clr_lvl = lv; clr_src = sr;
    step();
    post_vld = 1'b0; clr_vld = 1'b0; clr_all = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0]  exp_id;
    logic [31:0] exp_sum;
    rst = 1'b1; post_vld = 0; clr_vld = 0; clr_all = 0; ack = 0;
    post_lvl = 0; post_src = 0; clr_lvl = 0; clr_src = 0;
    sw_req = '0; cur_ipl = '0; pc_lo = 2'b00; ast_req = '0;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R12 reset state
    check("R12 pending", int_pending, 0);
    check("R12 take", take_int, 0);
    check("R12 id", int_id, 0);
    check("R12 summary", int_summary, 0);
    check("R12 errors", {err_range, err_ack, err_async}, 0);

    // R8 acknowledge with nothing stored
    ack = 1'b1; step(); ack = 1'b0;
    check("R8 err_ack", err_ack, 1);
    check("R8 id held", int_id, 0);
    step();

    // Table walk
    exp_id = '0; exp_sum = '0;
    for (int k = 0; k < 13; k++) begin
      sw_req = TBL[k].sw; cur_ipl = TBL[k].ipl;
      strobe(TBL[k].op == 2'd1, TBL[k].op == 2'd2, TBL[k].op == 2'd3,
             TBL[k].lvl, TBL[k].src);
      step();
      check("R4 table pending", int_pending, TBL[k].pend);
      check("R7 table take", take_int, TBL[k].take);
      if (TBL[k].take) begin
        ack = 1'b1; exp_id = TBL[k].id; exp_sum = TBL[k].sum;
      end
      step();
      ack = 1'b0;
      check("R8 table id", int_id, exp_id);
      check("R8 table summary", int_summary, exp_sum);
    end
    sw_req = '0; cur_ipl = '0;

    // R4 misaligned PC masks pending while take still fires
    pc_lo = 2'b01;
    strobe(1, 0, 0, 8'd20, 8'd1);
    step();
    check("R4 masked pending", int_pending, 0);
    check("R1 take with masked pc", take_int, 1);
    pc_lo = 2'b00; step();
    check("R4 aligned pending", int_pending, 1);

    // R2 level stays active while another source remains
    strobe(1, 0, 0, 8'd20, 8'd2);
    strobe(0, 1, 0, 8'd20, 8'd1);
    step();
    check("R2 other source holds", int_pending, 1);
    check("R2 take kept", take_int, 1);
    strobe(0, 1, 0, 8'd20, 8'd2);
    step();
    check("R2 last source gone", int_pending, 0);
    check("R2 no take", take_int, 0);

    // R11 post and clear same bit
    strobe(1, 1, 0, 8'd25, 8'd7);
    step();
    check("R11 clear wins pending", int_pending, 0);
    check("R11 clear wins take", take_int, 0);

    // R3 clear-all beats a same-cycle post
    strobe(1, 0, 0, 8'd22, 8'd0);
    post_vld = 1'b1; post_lvl = 8'd23; post_src = 8'd0; clr_all = 1'b1;
    step();
    post_vld = 1'b0; clr_all = 1'b0;
    step();
    check("R3 cleared pending", int_pending, 0);
    check("R3 cleared take", take_int, 0);

    // R9 out-of-range indices
    strobe(1, 0, 0, 8'd40, 8'd0);
    check("R9 bad level post", err_range, 1);
    step();
    check("R9 bad level no effect", int_pending, 0);
    strobe(1, 0, 0, 8'd3, 8'd64);
    check("R9 bad source post", err_range, 1);
    step();
    check("R9 bad source no effect", int_pending, 0);
    strobe(0, 1, 0, 8'd33, 8'd0);
    check("R9 bad level clear", err_range, 1);

    // R10 asynchronous-trap request
    strobe(1, 0, 0, 8'd20, 8'd0);
    step();
    check("R10 take before request", take_int, 1);
    ast_req = 4'h2; step();
    check("R10 take suppressed", take_int, 0);
    check("R10 err_async", err_async, 1);
    ast_req = '0;
    strobe(0, 0, 1, 8'd0, 8'd0);
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule